// File: doc/BRIEF.md
# Single-Channel DMA Engine with Cycle-Steal and Burst Bus Sharing

This block moves a block of words between one peripheral data port and system memory without the processor touching each word. The processor programs a starting memory address, a word count and a device identifier through a small register write port. It then issues a start command that carries the transfer direction and the bus-sharing policy. The engine asks for the system bus and moves words only while it holds the grant. It steps the address up and the count down after every word. When the last word has moved it raises an interrupt, which stays high until the processor clears it.

There are two bus-sharing policies. In cycle-steal mode the engine gives the bus back after each word and stays off it for at least one cycle before it asks again, so the processor can run between words. In burst mode it keeps the bus request asserted from the first grant until the final word, which holds the processor off for the whole block. A word moves only in a cycle where the device reports ready. Memory reads are asynchronous: read data is used in the same cycle as the address.

Top module: `dma_engine`

## Requirements
- R1: Register writes use `cfg_sel` = 1 for the start address, 2 for the word count (low CW bits) and 3 for the device identifier (low DEVW bits). `cfg_sel` = 0 is the control word, with bit 0 start, bit 1 direction (0 = device to memory, 1 = memory to device), bit 2 policy (1 = burst, 0 = cycle-steal) and bit 3 interrupt clear. `dev_id` presents the programmed device identifier during every word of the block.
- R2: In device-to-memory direction, each word asserts `dev_rd` and `mem_we` in the same cycle, with `mem_wdata` equal to `dev_rdata`. `mem_re` and `dev_we` stay low.
- R3: In memory-to-device direction, each word asserts `mem_re` and `dev_we` in the same cycle, with `dev_wdata` equal to `mem_rdata` at `mem_addr`. `mem_we` and `dev_rd` stay low.
- R4: A block of N words starting at address A moves exactly N words, at addresses A, A+1, ..., A+N-1 in that order. The address advances by one after every word.
- R5: `bus_req` rises in the cycle after an accepted start. No memory or device strobe is asserted unless `bus_req` and `bus_grant` are both high.
- R6: A word is moved only in a cycle in which `dev_ready` is high.
- R7: In cycle-steal mode, after every word except the last, `bus_req` is low in the following cycle.
- R8: In burst mode, `bus_req` stays high from the first word until the final word.
- R9: In the cycle after the final word, `irq` is high and `bus_req` is low. After reset, `irq`, `bus_req` and all strobes are low.
- R10: `irq` stays high until a control write with bit 3 set. It is low in the cycle after that write.
- R11: While a block is in progress, a start command and writes to the address, count and device registers are all ignored. No extra word moves, and a later start reuses the values programmed before the block.
- R12: A start with a programmed count of zero sets `irq` in the next cycle and never raises `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (asynchronous) |
| dev_id | output | DEVW | Selected device identifier |
| dev_ready | input | 1 | Device can move a word this cycle |
| dev_rd | output | 1 | Device data consumed |
| dev_rdata | input | DW | Data from device |
| dev_we | output | 1 | Device data write strobe |
| dev_wdata | output | DW | Data to device |
| irq | output | 1 | Block-complete interrupt (sticky) |

## Verification
A working address that is off or stuck shows up at the very next strobe as a wrong `mem_addr`. That is at most one word after the fault. A count that is off shows up at the end of the block as `irq` rising a word too early or too late, or as an unexpected extra word. A sequencer stuck in the wrong state shows up within one cycle of a word, as a `bus_req` level that breaks the pattern of the selected policy. It can also show up as a strobe with no grant. A start that was taken while busy, or a register that accepted a write while busy, shows up only on the next block, as words at the wrong addresses. For that reason the bench replays a block after such writes.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_OWN  = 2'd2,
    XS_GAP  = 2'd3
  } xfer_state_t;

  // register select codes
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_DEV   = 2'd3;

  // control word bit positions
  localparam int CB_START = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_BURST = 2;
  localparam int CB_CLR   = 3;
endpackage

// File: rtl/dma_cfg_regs.sv
`timescale 1ns/1ps
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 12,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [AW-1:0]   wdata,
  input  logic            active,
  output logic [AW-1:0]   prog_addr,
  output logic [CW-1:0]   prog_count,
  output logic [DEVW-1:0] prog_dev,
  output logic            start_cmd,
  output logic            clr_cmd,
  output logic            cmd_dir,
  output logic            cmd_burst
);
  logic ctrl_wr;

  assign ctrl_wr   = we && (sel == SEL_CTRL);
  assign start_cmd = ctrl_wr && wdata[CB_START] && !active;
  assign clr_cmd   = ctrl_wr && wdata[CB_CLR];
  assign cmd_dir   = wdata[CB_DIR];
  assign cmd_burst = wdata[CB_BURST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_addr  <= '0;
      prog_count <= '0;
      prog_dev   <= '0;
    end else if (we && !active) begin
      case (sel)
        SEL_ADDR:  prog_addr  <= wdata;
        SEL_COUNT: prog_count <= wdata[CW-1:0];
        SEL_DEV:   prog_dev   <= wdata[DEVW-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
`timescale 1ns/1ps
module dma_xfer_ctrl
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 12,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_cmd,
  input  logic            cmd_dir,
  input  logic            cmd_burst,
  input  logic [AW-1:0]   prog_addr,
  input  logic [CW-1:0]   prog_count,
  input  logic [DEVW-1:0] prog_dev,
  input  logic            bus_grant,
  input  logic            dev_ready,
  output logic            bus_req,
  output logic            active,
  output logic            word_go,
  output logic            last_word,
  output logic            zero_start,
  output logic [AW-1:0]   cur_addr,
  output logic [DEVW-1:0] cur_dev,
  output logic            dir_m2d,
  output logic            burst_mode
);
  xfer_state_t     state;
  logic [CW-1:0]   remain;

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] count_after(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  function automatic logic is_final(input logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  assign zero_start = start_cmd && (prog_count == '0);
  assign word_go    = (state == XS_OWN) && bus_grant && dev_ready;
  assign last_word  = word_go && is_final(remain);
  assign bus_req    = (state == XS_REQ) || (state == XS_OWN);
  assign active     = (state != XS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= XS_IDLE;
      remain     <= '0;
      cur_addr   <= '0;
      cur_dev    <= '0;
      dir_m2d    <= 1'b0;
      burst_mode <= 1'b0;
    end else begin
      case (state)
        XS_IDLE: if (start_cmd && !zero_start) begin
          state      <= XS_REQ;
          remain     <= prog_count;
          cur_addr   <= prog_addr;
          cur_dev    <= prog_dev;
          dir_m2d    <= cmd_dir;
          burst_mode <= cmd_burst;
        end
        XS_REQ: if (bus_grant) state <= XS_OWN;
        XS_OWN: if (word_go) begin
          cur_addr <= addr_after(cur_addr);
          remain   <= count_after(remain);
          if (last_word)        state <= XS_IDLE;
          else if (!burst_mode) state <= XS_GAP;
        end
        XS_GAP:  state <= XS_REQ;
        default: state <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_port_steer.sv
`timescale 1ns/1ps
module dma_port_steer #(
  parameter int DW = 16
) (
  input  logic          word_go,
  input  logic          dir_m2d,
  input  logic [DW-1:0] dev_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          dev_rd,
  output logic          dev_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dev_wdata
);
  assign mem_we    = word_go && !dir_m2d;
  assign dev_rd    = word_go && !dir_m2d;
  assign mem_re    = word_go && dir_m2d;
  assign dev_we    = word_go && dir_m2d;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
endmodule

// File: rtl/dma_engine.sv
`timescale 1ns/1ps
module dma_engine #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int CW   = 12,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  output logic            bus_req,
  input  logic            bus_grant,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DEVW-1:0] dev_id,
  input  logic            dev_ready,
  output logic            dev_rd,
  input  logic [DW-1:0]   dev_rdata,
  output logic            dev_we,
  output logic [DW-1:0]   dev_wdata,
  output logic            irq
);
  // internal events, named for the checker
  logic [AW-1:0]   prog_addr;
  logic [CW-1:0]   prog_count;
  logic [DEVW-1:0] prog_dev;
  logic            start_cmd, clr_cmd, cmd_dir, cmd_burst;
  logic            active, word_go, last_word, zero_start;
  logic            dir_m2d, burst_mode;

  dma_cfg_regs #(.AW(AW), .CW(CW), .DEVW(DEVW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .active(active), .prog_addr(prog_addr), .prog_count(prog_count),
    .prog_dev(prog_dev), .start_cmd(start_cmd), .clr_cmd(clr_cmd),
    .cmd_dir(cmd_dir), .cmd_burst(cmd_burst)
  );

  dma_xfer_ctrl #(.AW(AW), .CW(CW), .DEVW(DEVW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .cmd_dir(cmd_dir),
    .cmd_burst(cmd_burst), .prog_addr(prog_addr), .prog_count(prog_count),
    .prog_dev(prog_dev), .bus_grant(bus_grant), .dev_ready(dev_ready),
    .bus_req(bus_req), .active(active), .word_go(word_go),
    .last_word(last_word), .zero_start(zero_start), .cur_addr(mem_addr),
    .cur_dev(dev_id), .dir_m2d(dir_m2d), .burst_mode(burst_mode)
  );

  dma_port_steer #(.DW(DW)) u_steer (
    .word_go(word_go), .dir_m2d(dir_m2d), .dev_rdata(dev_rdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .dev_rd(dev_rd), .dev_we(dev_we), .mem_wdata(mem_wdata),
    .dev_wdata(dev_wdata)
  );

  // sticky completion flag: setting wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n)                       irq <= 1'b0;
    else if (last_word || zero_start) irq <= 1'b1;
    else if (clr_cmd)                 irq <= 1'b0;
  end
endmodule

// File: rtl/dma_engine_chk.sv
`timescale 1ns/1ps
module dma_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          mem_we,
  input logic          mem_re,
  input logic          dev_rd,
  input logic          dev_we,
  input logic          dev_ready,
  input logic          irq,
  input logic          word_go,
  input logic          last_word,
  input logic          burst_mode,
  input logic          zero_start,
  input logic          clr_cmd,
  input logic [AW-1:0] mem_addr
);
  assert_grant_before_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || dev_rd || dev_we) |-> (bus_grant && bus_req));

  assert_word_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_go |-> dev_ready);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_go |=> (mem_addr == $past(mem_addr) + AW'(1)));

  assert_steal_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_go && !last_word && !burst_mode) |=> !bus_req);

  assert_burst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_go && !last_word && burst_mode) |=> bus_req);

  assert_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (irq && !bus_req));

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_cmd) |=> irq);

  assert_zero_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (irq && !bus_req));
endmodule

bind dma_engine dma_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
  .mem_we(mem_we), .mem_re(mem_re), .dev_rd(dev_rd), .dev_we(dev_we),
  .dev_ready(dev_ready), .irq(irq), .word_go(word_go),
  .last_word(last_word), .burst_mode(burst_mode), .zero_start(zero_start),
  .clr_cmd(clr_cmd), .mem_addr(mem_addr)
);

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
module dma_engine_tb;
  import dma_pkg::*;
  localparam int AW = 16, DW = 16, CW = 12, DEVW = 4;

  typedef struct packed { logic [15:0] a; logic [15:0] d; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = '0;
  logic [AW-1:0]   cfg_wdata = '0;
  logic            bus_req, bus_grant;
  logic [AW-1:0]   mem_addr;
  logic            mem_we, mem_re, dev_rd, dev_we, irq;
  logic [DW-1:0]   mem_wdata, mem_rdata, dev_rdata, dev_wdata;
  logic [DEVW-1:0] dev_id;
  logic            dev_ready;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  logic tb_m2d = 1'b0, tb_burst = 1'b0, rdy_toggle = 1'b0;
  logic [DEVW-1:0] tb_dev = '0;
  logic gap_chk = 1'b0, end_chk = 1'b0, in_burst = 1'b0;

  logic [15:0] mem [0:255];
  logic [15:0] dev_src;

  dma_engine #(.AW(AW), .DW(DW), .CW(CW), .DEVW(DEVW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_id(dev_id),
    .dev_ready(dev_ready), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
    .dev_we(dev_we), .dev_wdata(dev_wdata), .irq(irq)
  );

  // processor side grants one cycle after each request
  always @(posedge clk)
    if (!rst_n) bus_grant <= 1'b0;
    else        bus_grant <= bus_req;

  always @(posedge clk)
    if (!rst_n) dev_ready <= 1'b1;
    else        dev_ready <= rdy_toggle ? ~dev_ready : 1'b1;

  // memory and device source models
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'hA000 + 16'(i * 7);
      dev_src <= 16'h0100;
    end else begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (dev_rd) dev_src <= dev_src + 16'd3;
    end
  end
  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = dev_src;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pops expected words and checks bus pattern
  always @(negedge clk) begin
    if (rst_n) begin
      if (gap_chk) begin
        chk(!bus_req, "R7 request dropped after stolen word", 32'(bus_req), 0);
        gap_chk = 1'b0;
      end
      if (end_chk) begin
        chk(irq && !bus_req, "R9 irq up and bus released after last word",
            {30'd0, irq, bus_req}, 32'h2);
        end_chk = 1'b0;
      end
      if (in_burst)
        chk(bus_req, "R8 request held during burst", 32'(bus_req), 1);
      if (mem_we || mem_re || dev_we || dev_rd) begin
        chk(bus_grant && bus_req, "R5 strobe only under grant",
            {30'd0, bus_req, bus_grant}, 32'h3);
        chk(dev_ready, "R6 word only when device ready", 32'(dev_ready), 1);
        chk(dev_id == tb_dev, "R1 device identifier", 32'(dev_id), 32'(tb_dev));
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected extra word", 32'(mem_addr), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(mem_addr == e.a, "R4 word address", 32'(mem_addr), 32'(e.a));
          if (!tb_m2d) begin
            chk(mem_we && dev_rd && !mem_re && !dev_we, "R2 strobe set",
                {28'd0, mem_we, dev_rd, mem_re, dev_we}, 32'hC);
            chk(mem_wdata == e.d, "R2 data to memory", 32'(mem_wdata), 32'(e.d));
          end else begin
            chk(mem_re && dev_we && !mem_we && !dev_rd, "R3 strobe set",
                {28'd0, mem_we, dev_rd, mem_re, dev_we}, 32'h3);
            chk(dev_wdata == e.d, "R3 data to device", 32'(dev_wdata), 32'(e.d));
          end
          if (exp_q.size() == 0) begin
            end_chk  = 1'b1;
            in_burst = 1'b0;
          end else if (tb_burst) in_burst = 1'b1;
          else                   gap_chk  = 1'b1;
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: programs a block and pushes the words it must produce
  task automatic run_block(input bit prog, input bit m2d, input bit burst,
                           input logic [15:0] addr, input int n,
                           input logic [DEVW-1:0] dev);
    if (prog) begin
      cfg_write(SEL_ADDR, addr);
      cfg_write(SEL_COUNT, AW'(n));
      cfg_write(SEL_DEV, AW'(dev));
    end
    tb_m2d = m2d; tb_burst = burst; tb_dev = dev;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.a = addr + 16'(i);
      e.d = m2d ? mem[e.a[7:0]] : dev_src + 16'(3 * i);
      exp_q.push_back(e);
    end
    cfg_write(SEL_CTRL, AW'((m2d << CB_DIR) | (burst << CB_BURST) | (1 << CB_START)));
    chk(bus_req, "R5 request in cycle after start", 32'(bus_req), 1);
  endtask

  task automatic wait_irq(input string tag);
    int n;
    n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(irq, tag, 32'(irq), 1);
    chk(exp_q.size() == 0, "R4 all words moved", 32'(exp_q.size()), 0);
  endtask

  task automatic clear_irq();
    cfg_write(SEL_CTRL, AW'(1 << CB_CLR));
    chk(!irq, "R10 irq cleared by control write", 32'(irq), 0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !irq && !mem_we && !mem_re && !dev_rd && !dev_we,
        "R9 reset state quiet", {26'd0, bus_req, irq, mem_we, mem_re, dev_rd, dev_we}, 0);

    // device to memory, burst, device always ready
    run_block(1, 0, 1, 16'h0010, 4, 4'h3);
    wait_irq("R9 burst block completes");
    repeat (5) @(negedge clk);
    chk(irq, "R10 irq held without clear", 32'(irq), 1);
    clear_irq();

    // memory to device, cycle-steal, ready toggling
    rdy_toggle = 1'b1;
    run_block(1, 1, 0, 16'h0020, 3, 4'h7);
    wait_irq("R9 steal block completes");
    clear_irq();

    // read back the burst block written earlier, burst memory to device
    run_block(1, 1, 1, 16'h0010, 4, 4'h2);
    wait_irq("R9 readback completes");
    clear_irq();

    // writes and start while busy are ignored
    run_block(1, 1, 0, 16'h0030, 6, 4'h5);
    repeat (2) @(negedge clk);
    cfg_write(SEL_ADDR, 16'h0060);
    cfg_write(SEL_COUNT, 16'd7);
    cfg_write(SEL_DEV, 16'h9);
    cfg_write(SEL_CTRL, AW'((1 << CB_BURST) | (1 << CB_START)));
    wait_irq("R11 block unaffected by busy writes");
    repeat (20) @(negedge clk);
    chk(!bus_req, "R11 no request after ignored start", 32'(bus_req), 0);
    clear_irq();
    // restart without reprogramming: old address, count, device reused
    run_block(0, 1, 0, 16'h0030, 6, 4'h5);
    wait_irq("R11 restart uses earlier programming");
    clear_irq();

    // zero count
    cfg_write(SEL_COUNT, 16'd0);
    cfg_write(SEL_CTRL, AW'(1 << CB_START));
    chk(irq, "R12 zero count raises irq at once", 32'(irq), 1);
    for (int i = 0; i < 10; i++) begin
      chk(!bus_req, "R12 zero count never requests bus", 32'(bus_req), 0);
      @(negedge clk);
    end
    clear_irq();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule